// File: doc/BRIEF.md
# Framed SPI Master Transfer Engine

This block runs the serial side of an SPI master that moves data in frames. A frame holds a configurable number of words, and each word is between 8 and 32 bits long. Transmit words come from a FIFO and are kept in the upper bits of a 32-bit entry. Received words go back to a FIFO in the same upper-aligned form, with the unused low bits cleared. The block also drives a frame-sync (chip-select) line. Its polarity is selectable. Its timing relative to frame start and to the first data bit is set by delay codes in half-bit steps. Delay settings that are out of range are refused.

Software brings the engine up by raising four enable requests in a fixed order: clock, receive, transmit, frame-sync. Each request is acknowledged only when the one below it is already acknowledged. Raising the frame-sync acknowledge launches a frame. Shutdown runs in the opposite order. The serial clock divider and the FIFO storage are outside the block: it receives a half-bit strobe and connects to FIFO pop and push ports. It raises end-of-frame flags, flags a transmit underflow, and sets the data-out pin level whenever transmit is not active.

Top module: `fspi_frame_master`

## Requirements
- R1: While reset is asserted, all of the following hold: every enable acknowledge is 0, `sclk` is 0, `frame_sync` sits at its inactive level (equal to `sync_act_low`), `tx_pop` and `rx_push` are 0, and `tx_eof`, `rx_eof` and `tx_udf` are 0.
- R2: Enable index order is clock=0, receive=1, transmit=2, frame-sync=3. The acknowledge for index i rises one clock after its request is seen high, but only if acknowledge i-1 is already set. Index 0 has no such condition.
- R3: The acknowledge for index i falls one clock after its request is seen low, but only if acknowledge i+1 is already clear. Index 3 has no such condition.
- R4: A word of N = `bit_len_m1`+1 bits is taken from bits 31..32-N of its FIFO entry. The frame carries `word_cnt_m1`+1 words. With `lsb_first`=0 the word is sent on `mosi` from bit 31 downward, one bit per `sclk` period. Each bit is stable at the `sclk` rising edge.
- R5: With `lsb_first`=1, each word is sent starting at entry bit 32-N and going upward.
- R6: `miso` is sampled on each `sclk` rising edge. When a word's last bit is done, and receive is acknowledged, one `rx_push` delivers the word in the same bit order and alignment as transmit, with the low 32-N bits zero.
- R7: `frame_sync` is active high when `sync_act_low`=0 and active low when it is 1. It is active through every `sclk` high phase of a frame and inactive once the frame ends.
- R8: Delay codes 0/1/2/3 mean 0/2/4/6 half-bits and codes 5/6/7 mean 1/3/5 half-bits. With sync delay S and data delay D in half-bits, `frame_sync` becomes active on the S+1-th strobe after launch. The first `sclk` rise then comes on the D+1-th strobe after that.
- R9: The frame-sync enable is not acknowledged if any of these holds: either code is 4, D exceeds 4 half-bits, S exceeds 6 half-bits, or S+D is odd.
- R10: After the last bit of the last word, `frame_sync` returns to inactive and `tx_eof` is set. `rx_eof` is also set if receive was acknowledged. Both flags clear at the next launch.
- R11: When transmit is not acknowledged, or `tx_mask`=1, or no frame is in its data phase, `mosi` follows `idle_mode`: 00 drives 0, 01 drives 1, 1x releases the pin (`mosi_oe`=0). A masked frame pops nothing.
- R12: If a word is due while `tx_empty`=1, all-zero data is sent in its place, nothing is popped, and `tx_udf` is set until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_stb | input | 1 | One-cycle strobe per half serial bit |
| en_req | input | 4 | Enable requests: clock, receive, transmit, frame-sync |
| bit_len_m1 | input | 5 | Bits per word minus one (7..31) |
| word_cnt_m1 | input | 6 | Words per frame minus one |
| lsb_first | input | 1 | 1 = least significant bit first |
| sync_act_low | input | 1 | 1 = frame sync active low |
| data_dly | input | 3 | Data delay code |
| sync_dly | input | 3 | Sync delay code |
| tx_mask | input | 1 | Mask transmit data onto the pin |
| idle_mode | input | 2 | Data-out level while transmit is inactive |
| tx_data | input | 32 | Head of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Consume the head of the transmit FIFO |
| rx_data | output | 32 | Received word, upper-aligned |
| rx_push | output | 1 | Write `rx_data` to the receive FIFO |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idles low |
| frame_sync | output | 1 | Frame sync / chip select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| en_ack | output | 4 | Enable acknowledges |
| tx_eof | output | 1 | Transmit end of frame |
| rx_eof | output | 1 | Receive end of frame |
| tx_udf | output | 1 | Transmit underflow seen this frame |

## Verification
Every result is registered one clock after the edge that causes it. An enable acknowledge appears one clock after its request, so the bench checks it two falling edges after driving the request. Strobe-driven results (sync assertion, each `sclk` edge, pushes and pops) change at the clock edge that ends the strobe's cycle. The bench therefore drives inputs just after the rising edge, samples everything on the falling edge, and measures delays by counting strobes seen before each transition, not by counting wall-clock cycles. End-of-frame is checked only after `tx_eof` is observed, and the bit streams and pushed words gathered during the frame are compared then.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  localparam int EN_CLK = 0;
  localparam int EN_RX  = 1;
  localparam int EN_TX  = 2;
  localparam int EN_FS  = 3;
  localparam int EN_N   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC_WAIT, ST_DATA_WAIT, ST_SHIFT, ST_DONE
  } fsm_e;

  // Delay code to half-bit count; code 4 maps to 8 and is refused later.
  function automatic logic [3:0] dly_half(input logic [2:0] code);
    logic [3:0] h;
    case (code)
      3'd5:    h = 4'd1;
      3'd6:    h = 4'd3;
      3'd7:    h = 4'd5;
      default: h = {code, 1'b0};
    endcase
    return h;
  endfunction
endpackage

// File: rtl/fspi_dly_check.sv
module fspi_dly_check #(
  parameter int MAX_DATA_HALF = 4,
  parameter int MAX_SYNC_HALF = 6
) (
  input  logic [2:0] data_dly,
  input  logic [2:0] sync_dly,
  output logic [3:0] data_half,
  output logic [3:0] sync_half,
  output logic       legal
);
  import fspi_pkg::*;

  always_comb begin
    data_half = dly_half(data_dly);
    sync_half = dly_half(sync_dly);
    legal = (data_dly != 3'd4) && (sync_dly != 3'd4) &&
            (int'(data_half) <= MAX_DATA_HALF) &&
            (int'(sync_half) <= MAX_SYNC_HALF) &&
            (data_half[0] == sync_half[0]);
  end
endmodule

// File: rtl/fspi_en_seq.sv
module fspi_en_seq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         fs_legal,
  output logic [N-1:0] ack,
  output logic         launch
);
  logic [N-1:0] ack_q, ack_d;

  for (genvar g = 0; g < N; g++) begin : g_en
    logic up_ok, dn_ok, gate_ok;
    if (g == 0) begin : g_lo
      assign up_ok = 1'b1;
    end else begin : g_lo
      assign up_ok = ack_q[g-1];
    end
    if (g == N-1) begin : g_hi
      assign dn_ok   = 1'b1;
      assign gate_ok = fs_legal;
    end else begin : g_hi
      assign dn_ok   = ~ack_q[g+1];
      assign gate_ok = 1'b1;
    end
    assign ack_d[g] = (req[g] && up_ok && gate_ok) ? 1'b1 :
                      (!req[g] && dn_ok)           ? 1'b0 : ack_q[g];

    if (g > 0) begin : g_up_chk
      // R2
      ack_order_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q[g]) |-> $past(ack_q[g-1]));
    end
    if (g < N-1) begin : g_dn_chk
      // R3
      ack_order_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q[g]) |-> !$past(ack_q[g+1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_d;
  end

  assign ack    = ack_q;
  assign launch = ack_d[N-1] & ~ack_q[N-1];

  // R9
  fs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q[N-1]) |-> $past(fs_legal));
endmodule

// File: rtl/fspi_shift_fsm.sv
module fspi_shift_fsm #(
  parameter int DW  = 32,
  parameter int BLW = 5,
  parameter int WCW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic           run,
  input  logic           tx_on,
  input  logic           rx_on,
  input  logic           half_stb,
  input  logic [BLW-1:0] bit_len_m1,
  input  logic [WCW-1:0] word_cnt_m1,
  input  logic           lsb_first,
  input  logic [3:0]     sync_half,
  input  logic [3:0]     data_half,
  input  logic [DW-1:0]  tx_data,
  input  logic           tx_empty,
  input  logic           miso,
  output logic           tx_pop,
  output logic           rx_push,
  output logic [DW-1:0]  rx_data,
  output logic           sclk,
  output logic           sync_on,
  output logic           mosi_bit,
  output logic           data_phase,
  output logic           tx_eof,
  output logic           rx_eof,
  output logic           tx_udf
);
  import fspi_pkg::*;
  localparam logic [BLW-1:0] TOP = BLW'(DW-1);

  fsm_e           st_q, st_d;
  logic [3:0]     cnt_q, cnt_d;
  logic           sclk_q, sclk_d, sync_q, sync_d;
  logic [DW-1:0]  tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d;
  logic [BLW-1:0] bit_q, bit_d, shamt;
  logic [WCW-1:0] word_q, word_d;
  logic           teof_q, teof_d, reof_q, reof_d, udf_q, udf_d;
  logic           load, push, sample;
  logic [DW-1:0]  fetch;

  assign shamt = TOP - bit_len_m1;
  assign fetch = (tx_on && !tx_empty) ? tx_data : '0;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sclk_d = sclk_q; sync_d = sync_q;
    tx_sh_d = tx_sh_q; rx_sh_d = rx_sh_q; bit_d = bit_q; word_d = word_q;
    teof_d = teof_q; reof_d = reof_q; udf_d = udf_q;
    load = 1'b0; push = 1'b0; sample = 1'b0;
    if (launch) begin
      st_d = ST_SYNC_WAIT; cnt_d = sync_half;
      teof_d = 1'b0; reof_d = 1'b0; udf_d = 1'b0;
    end else if (!run) begin
      st_d = ST_IDLE; sclk_d = 1'b0; sync_d = 1'b0;
    end else if (half_stb) begin
      case (st_q)
        ST_SYNC_WAIT:
          if (cnt_q == 4'd0) begin
            sync_d = 1'b1; cnt_d = data_half; st_d = ST_DATA_WAIT;
            load = 1'b1; word_d = '0;
          end else cnt_d = cnt_q - 4'd1;
        ST_DATA_WAIT:
          if (cnt_q == 4'd0) begin
            sclk_d = 1'b1; sample = 1'b1; st_d = ST_SHIFT;
          end else cnt_d = cnt_q - 4'd1;
        ST_SHIFT:
          if (!sclk_q) begin
            sclk_d = 1'b1; sample = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q != bit_len_m1) begin
              bit_d   = bit_q + 1'b1;
              tx_sh_d = lsb_first ? (tx_sh_q >> 1) : (tx_sh_q << 1);
            end else begin
              push = rx_on;
              if (word_q == word_cnt_m1) begin
                st_d = ST_DONE; sync_d = 1'b0; teof_d = 1'b1; reof_d = rx_on;
              end else begin
                load = 1'b1; word_d = word_q + 1'b1;
              end
            end
          end
        default: ;
      endcase
    end
    if (sample)
      rx_sh_d = lsb_first ? {miso, rx_sh_q[DW-1:1]} : {rx_sh_q[DW-2:0], miso};
    if (load) begin
      tx_sh_d = lsb_first ? (fetch >> shamt) : fetch;
      rx_sh_d = '0;
      bit_d   = '0;
      udf_d   = udf_d | (tx_on & tx_empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sclk_q <= 1'b0; sync_q <= 1'b0;
      tx_sh_q <= '0; rx_sh_q <= '0; bit_q <= '0; word_q <= '0;
      teof_q <= 1'b0; reof_q <= 1'b0; udf_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sclk_q <= sclk_d; sync_q <= sync_d;
      tx_sh_q <= tx_sh_d; rx_sh_q <= rx_sh_d; bit_q <= bit_d; word_q <= word_d;
      teof_q <= teof_d; reof_q <= reof_d; udf_q <= udf_d;
    end
  end

  assign tx_pop     = load & tx_on & ~tx_empty;
  assign rx_push    = push;
  assign rx_data    = lsb_first ? rx_sh_q : (rx_sh_q << shamt);
  assign sclk       = sclk_q;
  assign sync_on    = sync_q;
  assign mosi_bit   = lsb_first ? tx_sh_q[0] : tx_sh_q[DW-1];
  assign data_phase = (st_q == ST_DATA_WAIT) || (st_q == ST_SHIFT);
  assign tx_eof     = teof_q;
  assign rx_eof     = reof_q;
  assign tx_udf     = udf_q;

  // R4
  sclk_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk_q) && $past(run)) |-> $past(half_stb));
  // R8
  sync_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(half_stb));
  // R7
  sync_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> $past(run) || $past(launch));
  // R10
  eof_ends_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(teof_q) |-> $fell(sync_q));
  // R12
  udf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udf_q) |-> $past(tx_empty));
endmodule

// File: rtl/fspi_frame_master.sv
module fspi_frame_master #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 64,
  localparam int BLW      = $clog2(DW),
  localparam int WCW      = $clog2(MAX_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           half_stb,
  input  logic [3:0]     en_req,
  input  logic [BLW-1:0] bit_len_m1,
  input  logic [WCW-1:0] word_cnt_m1,
  input  logic           lsb_first,
  input  logic           sync_act_low,
  input  logic [2:0]     data_dly,
  input  logic [2:0]     sync_dly,
  input  logic           tx_mask,
  input  logic [1:0]     idle_mode,
  input  logic [DW-1:0]  tx_data,
  input  logic           tx_empty,
  output logic           tx_pop,
  output logic [DW-1:0]  rx_data,
  output logic           rx_push,
  input  logic           miso,
  output logic           sclk,
  output logic           frame_sync,
  output logic           mosi,
  output logic           mosi_oe,
  output logic [3:0]     en_ack,
  output logic           tx_eof,
  output logic           rx_eof,
  output logic           tx_udf
);
  import fspi_pkg::*;

  logic [3:0] data_half, sync_half;
  logic       legal, launch, sync_on, mosi_bit, data_phase, tx_on, tx_drive;

  fspi_dly_check u_dly (
    .data_dly(data_dly), .sync_dly(sync_dly),
    .data_half(data_half), .sync_half(sync_half), .legal(legal));

  fspi_en_seq #(.N(EN_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(en_req), .fs_legal(legal),
    .ack(en_ack), .launch(launch));

  assign tx_on = en_ack[EN_TX] & ~tx_mask;

  fspi_shift_fsm #(.DW(DW), .BLW(BLW), .WCW(WCW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(en_ack[EN_FS]),
    .tx_on(tx_on), .rx_on(en_ack[EN_RX]), .half_stb(half_stb),
    .bit_len_m1(bit_len_m1), .word_cnt_m1(word_cnt_m1), .lsb_first(lsb_first),
    .sync_half(sync_half), .data_half(data_half), .tx_data(tx_data),
    .tx_empty(tx_empty), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_data(rx_data), .sclk(sclk), .sync_on(sync_on), .mosi_bit(mosi_bit),
    .data_phase(data_phase), .tx_eof(tx_eof), .rx_eof(rx_eof), .tx_udf(tx_udf));

  assign tx_drive   = data_phase & tx_on;
  assign mosi       = tx_drive ? mosi_bit : (idle_mode == 2'b01);
  assign mosi_oe    = tx_drive | ~idle_mode[1];
  assign frame_sync = sync_on ^ sync_act_low;

  // R6
  push_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> en_ack[EN_RX] && sclk);
  // R11
  masked_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mask |-> !tx_pop);
endmodule

// File: tb/test_fspi_frame_master.sv
module test_fspi_frame_master;
  localparam int MW = 64;

  typedef struct packed {
    logic [5:0] nb; logic [6:0] nw; logic lsb; logic low;
    logic [2:0] sd; logic [2:0] dd; logic [7:0] seed; logic [6:0] fill;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{6'd8,  7'd4, 1'b0, 1'b1, 3'd0, 3'd0, 8'h3C, 7'd4},
    '{6'd32, 7'd3, 1'b1, 1'b0, 3'd3, 3'd2, 8'hA5, 7'd3},
    '{6'd13, 7'd2, 1'b1, 1'b1, 3'd5, 3'd5, 8'h5A, 7'd2},
    '{6'd16, 7'd2, 1'b0, 1'b0, 3'd7, 3'd6, 8'hC3, 7'd1},
    '{6'd24, 7'd1, 1'b0, 1'b1, 3'd1, 3'd0, 8'h0F, 7'd1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, half_stb, lsb_first, sync_act_low, tx_mask, miso, tx_empty;
  logic [3:0] en_req, en_ack;
  logic [4:0] bit_len_m1;
  logic [5:0] word_cnt_m1;
  logic [2:0] data_dly, sync_dly;
  logic [1:0] idle_mode;
  logic [31:0] tx_data, rx_data;
  logic tx_pop, rx_push, sclk, frame_sync, mosi, mosi_oe, tx_eof, rx_eof, tx_udf;

  fspi_frame_master i_fspi_frame_master (.*);

  logic [31:0] txq [MW];
  int wr, rd, n_chk, n_bad, cyc, pop_n, rx_n, mo_n, mi_idx, n_s, n_d, sync_bad;
  logic pop_req, seen_sync, seen_rise, prev_sclk;
  logic [7:0] seed_cur;
  logic [31:0] rxw [MW];
  logic mo_bits [256];

  assign tx_empty = (rd >= wr);
  assign tx_data  = (rd < MW) ? txq[rd] : 32'd0;

  function automatic logic [31:0] txw(input logic [7:0] s, input int k);
    return {s, 8'(k) ^ 8'h5A, ~s, s + 8'(k * 29)};
  endfunction
  function automatic logic mi_bit(input int i, input logic [7:0] s);
    return ((i * 5 + int'(s)) % 7) < 3;
  endfunction
  function automatic int half_of(input logic [2:0] c);
    return (c < 3'd4) ? 2 * int'(c) : 2 * (int'(c) - 5) + 1;
  endfunction

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // drive strobe and FIFO pointer just after the rising edge
  initial begin
    cyc = 0; rd = 0; pop_req = 1'b0; half_stb = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (pop_req) rd = rd + 1;
      pop_req = 1'b0;
      half_stb = (cyc % 4 == 3);
      cyc++;
    end
  end

  // sample outputs on the falling edge
  initial begin
    prev_sclk = 1'b0;
    forever begin
      @(negedge clk);
      if (tx_pop) begin pop_n++; pop_req = 1'b1; end
      if (rx_push && rx_n < MW) begin rxw[rx_n] = rx_data; rx_n++; end
      if (sclk && !prev_sclk && mo_n < 256) begin mo_bits[mo_n] = mosi; mo_n++; end
      if (!sclk && prev_sclk) begin mi_idx++; miso = mi_bit(mi_idx, seed_cur); end
      if (en_ack[3] && !seen_sync && half_stb && !(frame_sync ^ sync_act_low)) n_s++;
      if (frame_sync ^ sync_act_low) seen_sync = 1'b1;
      if (seen_sync && !seen_rise && half_stb && !sclk) n_d++;
      if (sclk) seen_rise = 1'b1;
      if (sclk && !(frame_sync ^ sync_act_low)) sync_bad++;
      prev_sclk = sclk;
    end
  end

  task automatic set_req(input int i, input logic v);
    @(posedge clk); #1; en_req[i] = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic clear_mon(input logic [7:0] s);
    pop_n = 0; rx_n = 0; mo_n = 0; mi_idx = 0; n_s = 0; n_d = 0; sync_bad = 0;
    seen_sync = 1'b0; seen_rise = 1'b0; seed_cur = s; miso = mi_bit(0, s);
  endtask

  task automatic wait_eof();
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (tx_eof) break;
    end
  endtask

  task automatic shut_down();
    for (int i = 3; i >= 0; i--) set_req(i, 1'b0);
  endtask

  task automatic run_vec(input vec_t v);
    int nb, nw, mism, s_h, d_h;
    logic [31:0] w, e;
    logic b;
    nb = int'(v.nb); nw = int'(v.nw); s_h = half_of(v.sd); d_h = half_of(v.dd);
    @(posedge clk); #1;
    bit_len_m1 = 5'(nb - 1); word_cnt_m1 = 6'(nw - 1); lsb_first = v.lsb;
    sync_act_low = v.low; sync_dly = v.sd; data_dly = v.dd; tx_mask = 1'b0;
    for (int k = 0; k < int'(v.fill); k++) txq[k] = txw(v.seed, k);
    rd = 0; wr = int'(v.fill);
    clear_mon(v.seed);
    for (int i = 0; i < 4; i++) set_req(i, 1'b1);
    wait_eof();
    @(negedge clk);
    chk("R10", "tx_eof", tx_eof, 1);
    chk("R10", "rx_eof", rx_eof, 1);
    chk("R7", "sync inactive after frame", frame_sync, v.low);
    chk("R7", "sync inactive while sclk high", sync_bad, 0);
    chk("R8", "strobes to sync", n_s, s_h + 1);
    chk("R8", "strobes sync to first rise", n_d, d_h + 1);
    chk("R4", "bits sent", mo_n, nb * nw);
    mism = 0;
    for (int g = 0; g < nb * nw && g < 256; g++) begin
      w = (g / nb < int'(v.fill)) ? txw(v.seed, g / nb) : 32'd0;
      w = w >> (32 - nb);
      b = v.lsb ? w[g % nb] : w[nb - 1 - (g % nb)];
      if (mo_bits[g] !== b) mism++;
    end
    chk(v.lsb ? "R5" : "R4", "mosi bit mismatches", mism, 0);
    chk("R6", "words pushed", rx_n, nw);
    for (int k = 0; k < nw && k < rx_n; k++) begin
      e = '0;
      for (int j = 0; j < nb; j++) begin
        if (v.lsb) e[j] = mi_bit(k * nb + j, v.seed);
        else       e[nb - 1 - j] = mi_bit(k * nb + j, v.seed);
      end
      e = e << (32 - nb);
      chk("R6", "received word", rxw[k], e);
    end
    chk("R12", "pops", pop_n, (int'(v.fill) < nw) ? int'(v.fill) : nw);
    chk("R12", "underflow flag", tx_udf, int'(v.fill) < nw);
    shut_down();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; wr = 0;
    rst_n = 1'b0; en_req = '0; bit_len_m1 = 5'd7; word_cnt_m1 = '0;
    lsb_first = 1'b0; sync_act_low = 1'b1; data_dly = '0; sync_dly = '0;
    tx_mask = 1'b0; idle_mode = 2'b00; miso = 1'b0; seed_cur = '0;
    clear_mon(8'd0);
    repeat (3) @(negedge clk);
    chk("R1", "ack in reset", en_ack, 0);
    chk("R1", "sclk in reset", sclk, 0);
    chk("R1", "sync in reset", frame_sync, 1);
    chk("R1", "pop/push in reset", {tx_pop, rx_push}, 0);
    chk("R1", "flags in reset", {tx_eof, rx_eof, tx_udf}, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R2: transmit enable refused without receive enable
    set_req(2, 1'b1);
    chk("R2", "tx ack without rx ack", en_ack[2], 0);
    set_req(2, 1'b0);
    set_req(0, 1'b1);
    chk("R2", "clock ack", en_ack[0], 1);
    set_req(1, 1'b1);
    set_req(2, 1'b1);
    chk("R2", "ordered acks", en_ack, 4'b0111);
    // R3: clock cannot drop while receive is up
    set_req(0, 1'b0);
    chk("R3", "clock ack held", en_ack[0], 1);
    set_req(0, 1'b1);
    // R9: illegal delay settings refuse frame-sync
    @(posedge clk); #1; sync_dly = 3'd5; data_dly = 3'd0;
    set_req(3, 1'b1);
    chk("R9", "odd sum refused", en_ack[3], 0);
    repeat (8) @(negedge clk);
    chk("R9", "no sync on refusal", frame_sync, sync_act_low);
    set_req(3, 1'b0);
    @(posedge clk); #1; sync_dly = 3'd1; data_dly = 3'd7;
    set_req(3, 1'b1);
    chk("R9", "data delay too long refused", en_ack[3], 0);
    set_req(3, 1'b0);
    @(posedge clk); #1; sync_dly = 3'd4; data_dly = 3'd0;
    set_req(3, 1'b1);
    chk("R9", "code 4 refused", en_ack[3], 0);
    shut_down();
    chk("R3", "all acks cleared", en_ack, 0);

    for (int t = 0; t < 5; t++) run_vec(VECS[t]);

    // R11: masked frame drives idle level, pops nothing
    @(posedge clk); #1;
    bit_len_m1 = 5'd7; word_cnt_m1 = '0; sync_dly = '0; data_dly = '0;
    sync_act_low = 1'b1; tx_mask = 1'b1; idle_mode = 2'b01;
    txq[0] = 32'h0; rd = 0; wr = 1;
    clear_mon(8'h11);
    for (int i = 0; i < 4; i++) set_req(i, 1'b1);
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (sclk) break;
    end
    chk("R11", "masked mosi level", {mosi, mosi_oe}, 2'b11);
    wait_eof();
    @(negedge clk);
    chk("R11", "masked pops", pop_n, 0);
    chk("R11", "masked frame no underflow", tx_udf, 0);
    shut_down();
    @(posedge clk); #1; tx_mask = 1'b0; idle_mode = 2'b10;
    @(negedge clk);
    chk("R11", "idle released", mosi_oe, 0);
    @(posedge clk); #1; idle_mode = 2'b00;
    @(negedge clk);
    chk("R11", "idle low", {mosi, mosi_oe}, 2'b01);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule